// File: doc/BRIEF.md
# Cascadable Rate-Generator Counter Router

This block contains three down-counters, each running in a divide-by-N rate-generator mode. It also holds the routing that decides which clock drives each counter and which gate enables it. A decade prescaler chain divides the system clock, which is taken as the base rate (10 MHz in the usual setting), into single-cycle enables at the base rate and at 1/10, 1/100, 1/1000 and 1/10000 of it. Each counter can instead be clocked by the rising edges of a neighbouring counter's output, or by a synchronised external clock pin. Each counter's gate can be held open or closed, follow a synchronised external gate pin, or follow the inverted output of a second neighbour.

The routing is set through two byte-wide select registers, one for clock sources and one for gate sources. Each write names one counter and one source code. Divisors are loaded through a separate port. A long-period pacer is built by clocking one counter from the base rate and clocking a second counter from the first counter's output. The second counter's output then forms a trigger whose period is the product of the two divisors.

Top module: `ctr_cascade_router`

## Requirements
- R1: After reset every counter has clock code 0 and gate code 1, and all three outputs are high.
- R2: A config byte carries the counter index in bits [4:3] and the source code in bits [2:0]. It is written to the clock register when cfg_sel is 0 and to the gate register when cfg_sel is 1. Index 3 names no counter, and a write with index 3 changes nothing.
- R3: A counter with divisor N (N at least 2) produces an output period of N clock ticks. The output is low for exactly one tick of each period. A divisor of 0 acts as 65536.
- R4: A divisor load sets both the divisor and the count at once, takes priority over a tick in the same cycle, and restarts the period: the output goes low N-1 ticks after the load. A divisor of 1 holds the output low.
- R5: Clock codes 1, 2, 3, 4 and 5 tick a counter at the base rate and at the base rate divided by 10, 100, 1000 and 10000.
- R6: Clock code 6 ticks counter n on each rising edge of the output of counter (n+2) mod 3. Two counters cascaded this way give a period equal to the product of their divisors, with a low time of one period of the feeding counter.
- R7: Clock code 7 ticks a counter on each rising edge of ext_clk after a two-stage synchroniser.
- R8: Clock code 0 is reserved and never ticks, whatever the gate does.
- R9: Gate code 0 enables counting and gate code 1 freezes the count. Gate code 2 follows the synchronised ext_gate level. Gate code 3 follows the inverted output of counter (n+1) mod 3. Codes 4 to 7 freeze the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, also the base counting rate |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for a select register |
| cfg_sel | input | 1 | 0 selects the clock register, 1 selects the gate register |
| cfg_data | input | 8 | Counter index in [4:3], source code in [2:0] |
| div_we | input | 1 | Divisor load strobe |
| div_idx | input | 2 | Counter that receives the divisor (index 3 is ignored) |
| div_val | input | 16 | Divisor value; 0 means 65536 |
| ext_clk | input | 1 | Asynchronous external clock |
| ext_gate | input | 1 | Asynchronous external gate level |
| cnt_out | output | 3 | Rate-generator outputs of counters 0, 1 and 2 |

## Verification
The bench goes after the places where a wrong design shows a wrong period or pulse width. These include a cascade whose low time would equal one system cycle if the neighbour edge were taken from the wrong counter, and a divisor of 0 that would give a period of 1 or of 65535 instead of 65536. It also checks that a reload which does not take priority over a tick lands one count late. It confirms that a reserved clock code or a closed gate leaves the output high indefinitely, and that a write with index 3 spills into no counter. Random divisor and prescale combinations confirm that the period scales with both.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   localparam int NUM_CNT = 3;
   localparam int SRC_W   = 3;

   typedef logic [SRC_W-1:0] src_t;

   localparam src_t CLK_RSVD  = 3'd0;
   localparam src_t CLK_BASE  = 3'd1;
   localparam src_t CLK_NEIGH = 3'd6;
   localparam src_t CLK_EXT   = 3'd7;

   localparam src_t GATE_OPEN  = 3'd0;
   localparam src_t GATE_SHUT  = 3'd1;
   localparam src_t GATE_EXT   = 3'd2;
   localparam src_t GATE_NEIGH = 3'd3;

   function automatic int clk_neigh(input int n);
      return (n + NUM_CNT - 1) % NUM_CNT;
   endfunction

   function automatic int gate_neigh(input int n);
      return (n + NUM_CNT - 2) % NUM_CNT;
   endfunction
endpackage

// File: rtl/ccr_prescale.sv
module ccr_prescale #(
   parameter int DECADE = 10,
   parameter int STAGES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   output logic [STAGES:0] en_o
);
   localparam int DW = (DECADE > 1) ? $clog2(DECADE) : 1;
   localparam logic [DW-1:0] LAST = DW'(DECADE - 1);

   assign en_o[0] = 1'b1;

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [DW-1:0] div_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (en_o[s]) begin
            div_q <= (div_q == LAST) ? '0 : div_q + 1'b1;
         end
      end
      assign en_o[s+1] = en_o[s] && (div_q == LAST);
   end
endmodule

// File: rtl/ccr_sync.sv
module ccr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic lvl_o,
   output logic rise_o
);
   logic [STAGES-1:0] pipe_q;
   logic              last_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe_q <= '0;
         last_q <= 1'b0;
      end else begin
         pipe_q <= {pipe_q[STAGES-2:0], d_i};
         last_q <= pipe_q[STAGES-1];
      end
   end

   assign lvl_o  = pipe_q[STAGES-1];
   assign rise_o = pipe_q[STAGES-1] && !last_q;
endmodule

// File: rtl/ccr_cfg.sv
module ccr_cfg
   import ccr_pkg::*;
(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            cfg_we,
   input  logic                            cfg_sel,
   input  logic [7:0]                      cfg_data,
   output logic [NUM_CNT-1:0][SRC_W-1:0]   clk_sel_o,
   output logic [NUM_CNT-1:0][SRC_W-1:0]   gate_sel_o
);
   logic [1:0] idx;
   src_t       code;

   assign idx  = cfg_data[4:3];
   assign code = cfg_data[2:0];

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_reg
      logic hit;
      assign hit = cfg_we && (idx == 2'(k));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            clk_sel_o[k]  <= CLK_RSVD;
            gate_sel_o[k] <= GATE_SHUT;
         end else if (hit) begin
            if (cfg_sel) gate_sel_o[k] <= code;
            else         clk_sel_o[k]  <= code;
         end
      end
   end
endmodule

// File: rtl/ccr_rate_gen.sv
module ccr_rate_gen #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] div_o,
   output logic             out_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q, div_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         div_q <= '0;
      end else if (load_i) begin
         cnt_q <= load_val_i;
         div_q <= load_val_i;
      end else if (tick_i) begin
         cnt_q <= (cnt_q == ONE) ? div_q : cnt_q - ONE;
      end
   end

   assign cnt_o = cnt_q;
   assign div_o = div_q;
   assign out_o = (cnt_q != ONE);
endmodule

// File: rtl/ctr_cascade_router.sv
module ctr_cascade_router
   import ccr_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int DECADE       = 10,
   parameter int PRESC_STAGES = 4,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic             cfg_sel,
   input  logic [7:0]       cfg_data,
   input  logic             div_we,
   input  logic [1:0]       div_idx,
   input  logic [CNT_W-1:0] div_val,
   input  logic             ext_clk,
   input  logic             ext_gate,
   output logic [2:0]       cnt_out
);
   localparam int LAST_PRESC_CODE = PRESC_STAGES + 1;

   if (CNT_W < 2) begin : g_bad_width
      $error("CNT_W must be at least 2");
   end
   if (PRESC_STAGES < 1 || PRESC_STAGES > 4) begin : g_bad_presc
      $error("PRESC_STAGES must lie in 1..4 to fit clock codes 1..5");
   end
   if (DECADE < 2) begin : g_bad_decade
      $error("DECADE must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PRESC_STAGES:0]               presc_en;
   logic [NUM_CNT-1:0][SRC_W-1:0]       clk_sel_q, gate_sel_q;
   logic [NUM_CNT-1:0][CNT_W-1:0]       cnt_vec, div_vec;
   logic [NUM_CNT-1:0]                  out_vec, out_d, nb_rise;
   logic [NUM_CNT-1:0]                  edge_vec, gate_vec, tick, load_vec;
   logic                                ext_clk_lvl, ext_clk_rise;
   logic                                ext_gate_lvl, ext_gate_rise;

   ccr_prescale #(.DECADE(DECADE), .STAGES(PRESC_STAGES)) u_presc (
      .clk(clk), .rst_n(rst_n), .en_o(presc_en)
   );

   ccr_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .d_i(ext_clk),
      .lvl_o(ext_clk_lvl), .rise_o(ext_clk_rise)
   );

   ccr_sync #(.STAGES(SYNC_STAGES)) u_sync_gate (
      .clk(clk), .rst_n(rst_n), .d_i(ext_gate),
      .lvl_o(ext_gate_lvl), .rise_o(ext_gate_rise)
   );

   ccr_cfg u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .clk_sel_o(clk_sel_q), .gate_sel_o(gate_sel_q)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) out_d <= '1;
      else        out_d <= out_vec;
   end
   assign nb_rise = out_vec & ~out_d;

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_cnt
      localparam int CNB = clk_neigh(k);
      localparam int GNB = gate_neigh(k);

      always_comb begin
         edge_vec[k] = 1'b0;
         if (clk_sel_q[k] == CLK_NEIGH) begin
            edge_vec[k] = nb_rise[CNB];
         end else if (clk_sel_q[k] == CLK_EXT) begin
            edge_vec[k] = ext_clk_rise;
         end else begin
            for (int s = 0; s <= PRESC_STAGES; s++) begin
               if (int'(clk_sel_q[k]) == s + 1 && s + 1 <= LAST_PRESC_CODE)
                  edge_vec[k] = presc_en[s];
            end
         end
      end

      always_comb begin
         case (gate_sel_q[k])
            GATE_OPEN:  gate_vec[k] = 1'b1;
            GATE_EXT:   gate_vec[k] = ext_gate_lvl;
            GATE_NEIGH: gate_vec[k] = ~out_vec[GNB];
            default:    gate_vec[k] = 1'b0;
         endcase
      end

      assign tick[k]     = edge_vec[k] && gate_vec[k];
      assign load_vec[k] = div_we && (div_idx == 2'(k));

      ccr_rate_gen #(.CNT_W(CNT_W)) u_rg (
         .clk(clk), .rst_n(rst_n), .load_i(load_vec[k]),
         .load_val_i(div_val), .tick_i(tick[k]),
         .cnt_o(cnt_vec[k]), .div_o(div_vec[k]), .out_o(out_vec[k])
      );
   end

   assign cnt_out = out_vec;

   logic unused_ok;
   assign unused_ok = ^{ext_clk_lvl, ext_gate_rise};
endmodule

// File: rtl/ctr_cascade_router_chk.sv
module ctr_cascade_router_chk
   import ccr_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input logic                          clk,
   input logic                          rst_n,
   input logic                          cfg_we,
   input logic [7:0]                    cfg_data,
   input logic [CNT_W-1:0]              div_val,
   input logic [NUM_CNT-1:0][SRC_W-1:0] clk_sel_q,
   input logic [NUM_CNT-1:0][SRC_W-1:0] gate_sel_q,
   input logic [NUM_CNT-1:0][CNT_W-1:0] cnt_vec,
   input logic [NUM_CNT-1:0][CNT_W-1:0] div_vec,
   input logic [NUM_CNT-1:0]            tick,
   input logic [NUM_CNT-1:0]            load_vec,
   input logic [2:0]                    cnt_out
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   // R1: reset leaves every counter idle with its output high
   a_r1_reset_idle: assert property (@(posedge clk)
      !rst_n |=> (cnt_out == 3'b111) && (clk_sel_q == '0));

   // R2: a write naming index 3 touches no select register
   a_r2_idx3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_data[4:3] == 2'd3) |=> ($stable(clk_sel_q) && $stable(gate_sel_q)));

   for (genvar k = 0; k < NUM_CNT; k++) begin : g_k
      // R3: each tick away from 1 steps the count down by one
      a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
         (tick[k] && !load_vec[k] && cnt_vec[k] != ONE) |=> cnt_vec[k] == $past(cnt_vec[k]) - ONE);

      // R3: the tick at 1 reloads the stored divisor
      a_r3_reload: assert property (@(posedge clk) disable iff (!rst_n)
         (tick[k] && !load_vec[k] && cnt_vec[k] == ONE) |=> cnt_vec[k] == $past(div_vec[k]));

      // R4: a load wins and sets the count
      a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
         load_vec[k] |=> cnt_vec[k] == $past(div_val));

      // R8: reserved clock code never moves the count
      a_r8_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
         (clk_sel_q[k] == CLK_RSVD && !load_vec[k]) |=> $stable(cnt_vec[k]));

      // R9: a shut gate freezes the count
      a_r9_gate_shut: assert property (@(posedge clk) disable iff (!rst_n)
         (gate_sel_q[k] == GATE_SHUT && !load_vec[k]) |=> $stable(cnt_vec[k]));
   end
endmodule

bind ctr_cascade_router ctr_cascade_router_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_data(cfg_data),
   .div_val(div_val), .clk_sel_q(clk_sel_q), .gate_sel_q(gate_sel_q),
   .cnt_vec(cnt_vec), .div_vec(div_vec), .tick(tick),
   .load_vec(load_vec), .cnt_out(cnt_out)
);

// File: tb/test_ctr_cascade_router.sv
module test_ctr_cascade_router;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0, cfg_sel = 1'b0;
   logic [7:0]  cfg_data = '0;
   logic        div_we = 1'b0;
   logic [1:0]  div_idx = '0;
   logic [15:0] div_val = '0;
   logic        ext_clk = 1'b0, ext_gate = 1'b0;
   logic [2:0]  cnt_out;

   int  n_chk = 0, n_fail = 0;
   bit  ext_run = 1'b0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   ctr_cascade_router i_ctr_cascade_router (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
      .cfg_data(cfg_data), .div_we(div_we), .div_idx(div_idx),
      .div_val(div_val), .ext_clk(ext_clk), .ext_gate(ext_gate),
      .cnt_out(cnt_out)
   );

   // external clock: 8 system cycles per period while enabled
   initial begin
      int ph = 0;
      forever begin
         @(negedge clk);
         if (ext_run) begin
            ph = ph + 1;
            if (ph == 4) begin ph = 0; ext_clk = ~ext_clk; end
         end
      end
   end

   function automatic int presc(input int code);
      int r = 1;
      for (int i = 1; i < code; i++) r = r * 10;
      return r;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic cfg(input bit sel, input int idx, input int src);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel;
      cfg_data = {3'b000, 2'(idx), 3'(src)};
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load(input int idx, input int val);
      @(negedge clk);
      div_we = 1'b1; div_idx = 2'(idx); div_val = 16'(val);
      @(negedge clk);
      div_we = 1'b0;
   endtask

   task automatic idle_all();
      for (int k = 0; k < 3; k++) begin
         cfg(1'b0, k, 0);
         cfg(1'b1, k, 1);
         load(k, 2);
      end
   endtask

   // cycles between falling edges and the low width that follows the first one
   task automatic measure(input int k, input int limit, output int per, output int low);
      bit prev, now;
      int t = 0;
      per = -1; low = -1;
      prev = cnt_out[k];
      while (t < limit) begin
         @(negedge clk); t++;
         now = cnt_out[k];
         if (prev && !now) break;
         prev = now;
      end
      if (t >= limit) return;
      low = 1; per = 1; prev = 1'b0;
      while (per < limit) begin
         @(negedge clk);
         now = cnt_out[k];
         if (!now && low == per) low++;
         if (prev && !now) return;
         prev = now;
         per++;
      end
      per = -1;
   endtask

   task automatic count_falls(input int k, input int cycles, output int n);
      bit prev = cnt_out[k];
      n = 0;
      for (int i = 0; i < cycles; i++) begin
         @(negedge clk);
         if (prev && !cnt_out[k]) n++;
         prev = cnt_out[k];
      end
   endtask

   initial begin
      int per, low, n;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk(cnt_out == 3'b111, "R1 outputs high after reset", int'(cnt_out), 7);
      count_falls(0, 100, n);
      chk(n == 0, "R1 counter 0 idle after reset", n, 0);

      // R8: reserved clock code with open gates
      for (int k = 0; k < 3; k++) cfg(1'b1, k, 0);
      load(1, 3);
      count_falls(1, 200, n);
      chk(n == 0 && cnt_out == 3'b111, "R8 reserved clock never ticks", n, 0);

      // R3/R5: base rate
      idle_all();
      cfg(1'b0, 0, 1); cfg(1'b1, 0, 0); load(0, 7);
      measure(0, 1000, per, low);
      chk(per == 7, "R3 period at base rate", per, 7);
      chk(low == 1, "R3 low for one tick", low, 1);

      // R2: index 3 write changes nothing
      cfg(1'b0, 3, 0); cfg(1'b1, 3, 1);
      measure(0, 1000, per, low);
      chk(per == 7, "R2 index 3 leaves counter 0 running", per, 7);
      count_falls(1, 100, n);
      chk(n == 0, "R2 index 3 leaves counter 1 idle", n, 0);

      // R4: reload restarts the period
      load(0, 50);
      @(negedge clk);
      load(0, 7);
      begin
         int first = -1;
         for (int i = 1; i <= 8; i++) begin
            @(negedge clk);
            if (!cnt_out[0] && first < 0) first = i;
         end
         chk(first == 6, "R4 first low N-1 ticks after load", first, 6);
      end

      // R5: random divisors on prescaled clocks
      for (int it = 0; it < 8; it++) begin
         int k = $urandom_range(0, 2);
         int nv = $urandom_range(2, 40);
         int src = $urandom_range(1, 2);
         idle_all();
         cfg(1'b0, k, src); cfg(1'b1, k, 0); load(k, nv);
         measure(k, 3000, per, low);
         chk(per == nv * presc(src), "R5 prescaled period", per, nv * presc(src));
         chk(low == presc(src), "R5 prescaled low width", low, presc(src));
      end

      // R5: slower prescale code
      idle_all();
      cfg(1'b0, 2, 3); cfg(1'b1, 2, 0); load(2, 3);
      measure(2, 2000, per, low);
      chk(per == 300, "R5 divide-by-100 source", per, 300);

      // R6: cascade counter 2 into counter 0
      idle_all();
      cfg(1'b0, 2, 1); cfg(1'b1, 2, 0); load(2, 6);
      cfg(1'b0, 0, 6); cfg(1'b1, 0, 0); load(0, 5);
      measure(0, 2000, per, low);
      chk(per == 30, "R6 cascade period product", per, 30);
      chk(low == 6, "R6 cascade low width", low, 6);

      // R7: external clock, 8 cycles per edge
      idle_all();
      ext_run = 1'b1;
      cfg(1'b0, 1, 7); cfg(1'b1, 1, 0); load(1, 5);
      measure(1, 2000, per, low);
      chk(per == 40, "R7 external clock period", per, 40);
      chk(low == 8, "R7 external clock low width", low, 8);
      ext_run = 1'b0;

      // R9: external gate
      idle_all();
      cfg(1'b0, 1, 1); cfg(1'b1, 1, 2); load(1, 4);
      ext_gate = 1'b0;
      count_falls(1, 100, n);
      chk(n == 0, "R9 ext gate low freezes", n, 0);
      ext_gate = 1'b1;
      measure(1, 500, per, low);
      chk(per == 4, "R9 ext gate high runs", per, 4);
      ext_gate = 1'b0;

      // R9/R4: neighbour gate, counter 1 gated by inverted counter 2 output
      idle_all();
      cfg(1'b0, 1, 1); cfg(1'b1, 1, 3); load(1, 9);
      count_falls(1, 100, n);
      chk(n == 0, "R9 neighbour gate closed while counter 2 high", n, 0);
      load(2, 1);
      chk(cnt_out[2] == 1'b0, "R4 divisor 1 holds output low", int'(cnt_out[2]), 0);
      measure(1, 500, per, low);
      chk(per == 9, "R9 neighbour gate open", per, 9);

      // R9: gate code above 3 freezes
      idle_all();
      cfg(1'b0, 0, 1); cfg(1'b1, 0, 5); load(0, 3);
      count_falls(0, 100, n);
      chk(n == 0, "R9 gate code 5 freezes", n, 0);

      // R3: divisor 0 means 65536
      idle_all();
      cfg(1'b0, 0, 1); cfg(1'b1, 0, 0); load(0, 0);
      measure(0, 140000, per, low);
      chk(per == 65536, "R3 divisor 0 period", per, 65536);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 195000) begin
         @(posedge clk); cyc++;
      end
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule